// File: doc/BRIEF.md
# DRAM Refresh Counter and Counter-Test Cycle Controller

This block is a clock-synchronous model of the control logic inside a dynamic RAM. It samples the active-low row strobe, column strobe, write enable and output enable, plus the multiplexed address pins, on a fast system clock. From the order of the strobe edges it classifies each row-strobe period as one of three kinds. A row-only refresh takes its row from the pins. A column-before-row refresh takes its row from an internal 11-bit refresh counter. A normal access takes its row from the pins and opens one or more columns in page fashion.

Within a column-before-row period, the column strobe can rise and then fall again while the row strobe stays low. That second fall turns the refresh into a counter-test access. The row is still the refresh counter's value, but the column is taken from the pins, and the access can read, write, or read and then write in the same period. A small storage array, indexed by the low bits of row and column, holds the data, so a full counter-test sequence can be carried out end to end: write a pattern, read and invert it through counter-addressed cycles, then read it back. The active row and column, the read and write enables and the counter value are all brought out for observation.

Top module: `dram_cbr_ctrl`

## Requirements
- R1: A row-only refresh is a period in which the row strobe falls while the column strobe is high, and no column strobe fall occurs before the row strobe rises. The pin row becomes the active row. When the row strobe rises, the refresh counter loads that row plus one, modulo 2048.
- R2: If the column strobe is already low when the row strobe falls, the period is a column-before-row cycle. The active row is the refresh counter value and the address pins have no effect on it.
- R3: The refresh counter is 11 bits wide and resets to 0. It advances by one, wrapping from 2047 to 0, when the row strobe rises at the end of any column-before-row cycle, with or without a test access. Normal access cycles leave it unchanged.
- R4: In a column-before-row cycle, a column strobe rise followed by a fall while the row strobe stays low opens a test access. The active column is address pins 9..0 at that fall and the active row stays the counter value.
- R5: In a normal access, the row strobe falls with the column strobe high, then the column strobe falls. Each column strobe fall in that period opens a column from pins 9..0 at that fall (page mode). The refresh counter is not affected.
- R6: An access opened with write enable high raises rd_en in the clock after the column strobe fall is sampled. rd_en stays high until the column strobe rises, the row strobe rises, or a write occurs.
- R7: Write enable low at the column strobe fall writes din at once (early write). A write enable fall while rd_en is high writes din at that clock (read-modify-write). Either write gives a one-clock wr_en pulse and clears rd_en.
- R8: dq_oe goes high one clock after rd_en is high and oe_n is low in the same sample, and is low otherwise. While dq_oe is high, dout holds the stored word at the active row and column.
- R9: The array is addressed by row bits 3..0 and column bits 2..0. A word written through any cycle kind reads back unchanged through any other.
- R10: A synchronous active-high reset clears the counter, the active row and column, rd_en, wr_en and dq_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address pins |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, valid while dq_oe is high |
| dq_oe | output | 1 | Data output drive enable (low means high impedance) |
| act_row | output | 11 | Row of the current period |
| act_col | output | 10 | Column of the current access |
| rd_en | output | 1 | Read active |
| wr_en | output | 1 | One-clock write pulse |
| refresh_cnt | output | 11 | Internal refresh counter value |

## Verification
Eight row-only refreshes to consecutive rows put the counter at a known value. This separates loading from the pins from stepping the counter. Normal writes, column-before-row read-modify-write test cycles and normal reads then walk the same rows. Reading back data that was inverted through counter-addressed cycles shows whether the test row really came from the counter and the test column from the second column fall. Further cases cover a refresh with noise on the pins, a row-only refresh and a counter step that both wrap at 2047, an early write in a test cycle, and a two-column page read. These respectively show that the pins are ignored, that the wrap is correct, that early and late writes are told apart, and that page access works without touching the counter.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,     // row strobe low, row from pins, no column yet
    ST_PAGE,    // normal access, between columns
    ST_COL,     // normal access, column open
    ST_CBR,     // counter-row period, column strobe still low
    ST_CBR_HI,  // counter-row period, column strobe returned high
    ST_TCOL     // counter-test access, column open
  } cyc_e;
endpackage

// File: rtl/cbr_edge_det.sv
module cbr_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fall[i] = prev[i] & ~lvl[i];
    assign rise[i] = ~prev[i] & lvl[i];
  end
endmodule

// File: rtl/cbr_refresh_ctr.sv
module cbr_refresh_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbr_cell_array.sv
module cbr_cell_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dram_cbr_ctrl.sv
module dram_cbr_ctrl
  import cbr_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 8,
  parameter int ARR_ROW_BITS = 4,
  parameter int ARR_COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dq_oe,
  output logic [ROW_W-1:0]  act_row,
  output logic [COL_W-1:0]  act_col,
  output logic              rd_en,
  output logic              wr_en,
  output logic [ROW_W-1:0]  refresh_cnt
);
  localparam int ARR_AW = ARR_ROW_BITS + ARR_COL_BITS;

  cyc_e st;
  logic [2:0] fall, rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic in_cbr, in_col, col_open, rmw_wr, wr_go, ctr_load, ctr_step;
  logic [COL_W-1:0]  pin_col, wr_col;
  logic [ARR_AW-1:0] waddr, raddr;

  cbr_edge_det #(.N(3)) u_edges (
    .clk(clk), .rst(rst), .lvl({we_n, cas_n, ras_n}), .fall(fall), .rise(rise)
  );

  assign ras_fall = fall[0];
  assign ras_rise = rise[0];
  assign cas_fall = fall[1];
  assign cas_rise = rise[1];
  assign we_fall  = fall[2];
  assign pin_col  = addr[COL_W-1:0];

  always_comb begin
    in_cbr   = (st == ST_CBR) || (st == ST_CBR_HI) || (st == ST_TCOL);
    in_col   = (st == ST_COL) || (st == ST_TCOL);
    col_open = cas_fall && !ras_n &&
               ((st == ST_ROW) || (st == ST_PAGE) || (st == ST_CBR_HI));
    rmw_wr   = in_col && we_fall && rd_en && !cas_rise && !ras_rise;
    wr_go    = (col_open && !we_n) || rmw_wr;
    wr_col   = col_open ? pin_col : act_col;
    ctr_step = ras_rise && in_cbr;
    ctr_load = ras_rise && (st == ST_ROW);
    waddr    = {act_row[ARR_ROW_BITS-1:0], wr_col[ARR_COL_BITS-1:0]};
    raddr    = {act_row[ARR_ROW_BITS-1:0], act_col[ARR_COL_BITS-1:0]};
  end

  cbr_refresh_ctr #(.W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val(act_row + 1'b1),
    .step(ctr_step), .cnt(refresh_cnt)
  );

  cbr_cell_array #(.AW(ARR_AW), .DW(DATA_W)) u_array (
    .clk(clk), .we(wr_go), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      act_row <= '0;
      act_col <= '0;
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      dq_oe   <= 1'b0;
    end else begin
      wr_en <= wr_go;
      dq_oe <= rd_en & ~oe_n;
      if (col_open) begin
        act_col <= pin_col;
        rd_en   <= we_n;
      end else if (rmw_wr) begin
        rd_en <= 1'b0;
      end
      case (st)
        ST_IDLE:
          if (ras_fall) begin
            st      <= cas_n ? ST_ROW : ST_CBR;
            act_row <= cas_n ? addr : refresh_cnt;
          end
        ST_ROW, ST_PAGE:
          if (ras_rise)      st <= ST_IDLE;
          else if (col_open) st <= ST_COL;
        ST_COL:
          if (ras_rise) begin
            st <= ST_IDLE; rd_en <= 1'b0;
          end else if (cas_rise) begin
            st <= ST_PAGE; rd_en <= 1'b0;
          end
        ST_CBR:
          if (ras_rise)      st <= ST_IDLE;
          else if (cas_rise) st <= ST_CBR_HI;
        ST_CBR_HI:
          if (ras_rise)      st <= ST_IDLE;
          else if (col_open) st <= ST_TCOL;
        ST_TCOL:
          if (ras_rise) begin
            st <= ST_IDLE; rd_en <= 1'b0;
          end else if (cas_rise) begin
            st <= ST_CBR_HI; rd_en <= 1'b0;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_ctrl_checker.sv
module cbr_ctrl_checker
  import cbr_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             oe_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic             dq_oe,
  input logic [ROW_W-1:0] act_row,
  input logic [ROW_W-1:0] refresh_cnt,
  input cyc_e             st
);
  // R8: output drive follows a read and output enable one clock earlier
  assert_oe_follows_R8: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> ($past(rd_en) && !$past(oe_n)));

  // R7: the write strobe lasts a single clock
  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R7: a write ends the read
  assert_wr_ends_rd_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_en);

  // R3: the counter only moves right after a row strobe rise
  assert_cnt_on_ras_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (refresh_cnt != $past(refresh_cnt)) |-> ($past(ras_n) && !$past(ras_n, 2)));

  // R2: the row of a counter-row period equals the counter
  assert_cbr_row_R2: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_CBR) || (st == ST_CBR_HI) || (st == ST_TCOL)) |-> (act_row == refresh_cnt));

  // R6: a read is only live while the row strobe was low at the last edge
  assert_rd_in_ras_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !$past(ras_n));
endmodule

bind dram_cbr_ctrl cbr_ctrl_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .oe_n(oe_n), .rd_en(rd_en),
  .wr_en(wr_en), .dq_oe(dq_oe), .act_row(act_row),
  .refresh_cnt(refresh_cnt), .st(st)
);

// File: tb/dram_cbr_ctrl_bench.sv
module dram_cbr_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dq_oe, rd_en, wr_en;
  logic [10:0] act_row, refresh_cnt;
  logic [9:0]  act_col;

  int tests = 0, fails = 0;
  bit run = 0, done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dram_cbr_ctrl u_dram_cbr_ctrl (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe), .act_row(act_row),
    .act_col(act_col), .rd_en(rd_en), .wr_en(wr_en), .refresh_cnt(refresh_cnt)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] m_mem [128];
  int  m_cnt = 0, m_row = 0, m_col = 0;
  bit  m_open = 0, m_cbr = 0, m_cashi = 0, m_used = 0, m_colon = 0;
  bit  m_rd = 0, m_wr = 0, m_dq = 0;
  logic [7:0] m_dout;
  bit  p_ras = 1, p_cas = 1, p_we = 1;

  function automatic int idx(int r, int c);
    return (r % 16) * 8 + (c % 8);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_row = 0; m_col = 0; m_open = 0; m_cbr = 0; m_cashi = 0;
      m_used = 0; m_colon = 0; m_rd = 0; m_wr = 0; m_dq = 0;
      p_ras = 1; p_cas = 1; p_we = 1;
    end else begin
      bit rf, rr, cf, cr, wf;
      rf = p_ras && !ras_n; rr = !p_ras && ras_n;
      cf = p_cas && !cas_n; cr = !p_cas && cas_n;
      wf = p_we && !we_n;
      m_dq = m_rd && !oe_n;
      m_dout = m_mem[idx(m_row, m_col)];
      m_wr = 0;
      if (m_open) begin
        if (rr) begin
          if (m_cbr) m_cnt = (m_cnt + 1) % 2048;
          else if (!m_used) m_cnt = (m_row + 1) % 2048;
          m_open = 0; m_colon = 0; m_rd = 0; m_cbr = 0;
        end else if (m_colon) begin
          if (cr) begin m_colon = 0; m_rd = 0; end
          else if (wf && m_rd) begin
            m_mem[idx(m_row, m_col)] = din; m_wr = 1; m_rd = 0;
          end
        end else if (cf && (!m_cbr || m_cashi)) begin
          m_colon = 1; m_used = 1; m_col = int'(addr) % 1024;
          if (!we_n) begin m_mem[idx(m_row, m_col)] = din; m_wr = 1; m_rd = 0; end
          else m_rd = 1;
        end else if (cr && m_cbr) m_cashi = 1;
      end else if (rf) begin
        m_open = 1; m_used = 0; m_cashi = 0; m_cbr = !cas_n;
        m_row = m_cbr ? m_cnt : int'(addr);
      end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (run && !rst) begin
      chk("R2/R5 act_row", act_row, m_row);
      chk("R4/R5 act_col", act_col, m_col);
      chk("R6 rd_en", rd_en, m_rd);
      chk("R7 wr_en", wr_en, m_wr);
      chk("R3 refresh_cnt", refresh_cnt, m_cnt);
      chk("R8 dq_oe", dq_oe, m_dq);
      if (dq_oe) chk("R9 dout", dout, m_dout);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ras_only(int row);
    addr = 11'(row); ras_n = 0; step(2);
    ras_n = 1; step(2);
  endtask

  task automatic cbr_refresh();
    addr = 11'h555; cas_n = 0; step(1);
    ras_n = 0; step(2);
    addr = 11'h2AA; step(1);
    ras_n = 1; step(1);
    cas_n = 1; step(2);
  endtask

  task automatic nwrite(int row, int col, int data);
    addr = 11'(row); ras_n = 0; step(1);
    addr = 11'(col); din = 8'(data); we_n = 0; cas_n = 0; step(2);
    cas_n = 1; we_n = 1; step(1);
    ras_n = 1; step(2);
  endtask

  task automatic nread(int row, int col, int exp, string req);
    addr = 11'(row); ras_n = 0; step(1);
    addr = 11'(col); oe_n = 0; cas_n = 0; step(3);
    chk({req, " read drive"}, dq_oe, 1);
    chk({req, " read data"}, dout, exp);
    cas_n = 1; oe_n = 1; step(1);
    ras_n = 1; step(2);
  endtask

  task automatic cbr_rmw(int col, int wdata, int exp);
    cas_n = 0; step(1);
    ras_n = 0; step(2);
    cas_n = 1; step(1);
    addr = 11'(col); oe_n = 0; cas_n = 0; step(3);
    chk("R4/R8 test read drive", dq_oe, 1);
    chk("R4/R8 test read data", dout, exp);
    din = 8'(wdata); we_n = 0; step(1);
    chk("R7 rmw write pulse", wr_en, 1);
    we_n = 1; cas_n = 1; oe_n = 1; step(1);
    ras_n = 1; step(2);
  endtask

  task automatic cbr_early(int col, int wdata);
    cas_n = 0; step(1);
    ras_n = 0; step(2);
    cas_n = 1; step(1);
    addr = 11'(col); din = 8'(wdata); we_n = 0; cas_n = 0; step(1);
    chk("R7 early write pulse", wr_en, 1);
    chk("R7 early write no read", rd_en, 0);
    we_n = 1; cas_n = 1; step(1);
    ras_n = 1; step(2);
  endtask

  initial begin
    step(3);
    rst = 0;
    chk("R10 counter", refresh_cnt, 0);
    chk("R10 rd_en", rd_en, 0);
    chk("R10 wr_en", wr_en, 0);
    chk("R10 dq_oe", dq_oe, 0);
    run = 1;
    step(1);
    for (int r = 100; r < 108; r++) ras_only(r);
    chk("R1 counter after row-only refreshes", refresh_cnt, 108);
    for (int i = 0; i < 8; i++) nwrite(108 + i, 5, 8'h00);
    chk("R5 counter untouched by writes", refresh_cnt, 108);
    for (int i = 0; i < 8; i++) cbr_rmw(5, 8'hFF, 8'h00);
    chk("R3 counter after test cycles", refresh_cnt, 116);
    for (int i = 0; i < 8; i++) nread(108 + i, 5, 8'hFF, "R9");
    cbr_refresh();
    cbr_refresh();
    chk("R2 R3 counter after plain refreshes", refresh_cnt, 118);
    ras_only(11'h7FF);
    chk("R1 load wraps", refresh_cnt, 0);
    ras_only(11'h7FE);
    cbr_refresh();
    chk("R3 step wraps", refresh_cnt, 0);
    cbr_early(3, 8'hA5);
    chk("R3 after early-write test", refresh_cnt, 1);
    nread(0, 3, 8'hA5, "R7");
    nwrite(20, 1, 8'h3C);
    nwrite(20, 2, 8'hC3);
    addr = 11'd20; ras_n = 0; step(1);
    addr = 11'd1; oe_n = 0; cas_n = 0; step(3);
    chk("R5 page col 1", dout, 8'h3C);
    cas_n = 1; step(1);
    addr = 11'd2; cas_n = 0; step(3);
    chk("R5 page col 2", dout, 8'hC3);
    cas_n = 1; oe_n = 1; step(1);
    ras_n = 1; step(2);
    chk("R5 counter after page read", refresh_cnt, 1);
    chk("R8 idle no drive", dq_oe, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule